// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave side of a two-wire serial bus placed in front of a 256-byte memory. SCL and SDA are sampled with the system clock and passed through a synchronizer. Start and stop conditions are recognised in the sampled domain. Bytes are shifted MSB first, and the engine answers on the ninth clock by pulling SDA low through an open-drain output enable. The first byte after a start selects the device. It carries a fixed four-bit prefix, three bits compared with strap inputs, and a read/write bit. The second byte of a write loads the word address. Any further bytes are page data.

Page data is collected in a 16-entry buffer. It is copied into the array only when the self-timed write cycle ends. That cycle begins at the stop that closes a write carrying at least one data byte. While it runs, the engine ignores the bus entirely, so a master can poll with address bytes until it is acknowledged. A write-allow input, sampled at that stop, decides whether the commit takes effect. Reads stream bytes from an address counter that walks the whole array. Writes step only the low four address bits, so they stay inside one page.

Top module: `tw_eeprom_slave`

## Requirements
- R1: A start (SDA falls while SCL is high) begins a new device byte at any time outside the write cycle, and any partially shifted byte is dropped. A stop (SDA rises while SCL is high) returns the engine to idle.
- R2: After each accepted device, address or data byte, the slave holds SDA low for the whole ninth clock. Its SDA drive changes only while SCL is low.
- R3: A device byte is accepted only when bits 7:4 equal 1010 and bits 3:1 equal strap_i, with bit 0 as R/W (1 = read). On a mismatch the slave gives no acknowledge and ignores the bus until the next start.
- R4: Within a write, each data byte goes to the current address, and only address bits 3:0 then advance, wrapping inside the 16-byte page. A 17th byte overwrites the first byte's location.
- R5: Each byte read is followed by an increment of the full 8-bit address, wrapping from 0xFF to 0x00. The counter keeps its value between transactions, so a read with no address byte returns the byte at the last accessed address plus one.
- R6: A write transaction that carries only the word address loads the counter. It starts no write cycle, whether it ends in a stop or in a repeated start followed by a read.
- R7: During a read, the slave sends the next byte while the master acknowledges. After a master non-acknowledge it releases SDA and waits for the next start.
- R8: The stop ending a write with at least one data byte starts a write cycle of WR_CYCLES clocks. During it no address byte is acknowledged. After it the written bytes read back.
- R9: When wr_allow_i is low at that stop, every byte is still acknowledged and the write cycle still runs, but the array is left unchanged.
- R10: A repeated start after data bytes, with no stop in between, discards the buffered data and starts no write cycle.
- R11: After reset, SDA is released, the address counter is 0x00 and every array byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| strap_i | input | 3 | Device-select strap value |
| wr_allow_i | input | 1 | Write permission from the protection logic, sampled at the write-ending stop |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The checker assumes a well-behaved master. SCL stays high and low for several system clocks each. SDA changes only in the middle of SCL-low phases, except when a start or stop is deliberately made. The master never creates a start or stop while the slave is driving SDA. Under those conditions the slave's drive changes only while SCL is low, and it stays silent through every write cycle. The bench master keeps SCL phases at twelve clocks and moves SDA only at the midpoint of a low phase. It aborts bytes only during received-data phases, where the slave is not driving. Random transaction mixes therefore stay within those assumptions, including the cases where a byte is cut short.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_ADR,
    ST_ADR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tw_state_e;

endpackage

// File: rtl/tw_bus_sampler.sv
module tw_bus_sampler #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  localparam int unsigned PW = STAGES + 1;

  logic [PW-1:0] scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[PW-2:0], scl_i};
      sda_p <= {sda_p[PW-2:0], sda_i};
    end
  end

  // stage STAGES-1 is the current synchronized level, stage STAGES the previous one
  assign scl_lvl  = scl_p[STAGES-1];
  assign sda_lvl  = sda_p[STAGES-1];
  assign scl_rise = scl_p[STAGES-1] & ~scl_p[STAGES];
  assign scl_fall = ~scl_p[STAGES-1] & scl_p[STAGES];
  assign start_ev = scl_p[STAGES-1] & scl_p[STAGES] & sda_p[STAGES] & ~sda_p[STAGES-1];
  assign stop_ev  = scl_p[STAGES-1] & scl_p[STAGES] & ~sda_p[STAGES] & sda_p[STAGES-1];

endmodule

// File: rtl/tw_write_timer.sv
module tw_write_timer #(
  parameter int unsigned WR_CYCLES = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy,
  output logic done
);

  localparam int unsigned CW = $clog2(WR_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (go) begin
      cnt_d = CW'(WR_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));

endmodule

// File: rtl/tw_store.sv
module tw_store #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_clr,
  input  logic              buf_we,
  input  logic [PAGE_W-1:0] buf_idx,
  input  logic [7:0]        buf_din,
  input  logic              commit,
  input  logic [ADDR_W-PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned PB    = 1 << PAGE_W;
  localparam int unsigned PG_W  = ADDR_W - PAGE_W;

  logic [7:0]    buf_q [PB];
  logic [PB-1:0] mask_q;
  logic [7:0]    mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (buf_clr) begin
      mask_q <= '0;
    end else if (buf_we) begin
      mask_q[buf_idx] <= 1'b1;
    end
  end

  // data slots are only read where the mask bit is set, so they carry no reset
  always_ff @(posedge clk) begin
    if (buf_we) begin
      buf_q[buf_idx] <= buf_din;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam int unsigned PG  = g >> PAGE_W;
    localparam int unsigned OFF = g % PB;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (commit && (page == PG_W'(PG)) && mask_q[OFF]) begin
        mem_q[g] <= buf_q[OFF];
      end
    end
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned PAGE_W     = 4,
  parameter logic [3:0]  DEV_PREFIX = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              busy,
  input  logic [2:0]        strap,
  input  logic              wr_allow,
  input  logic [7:0]        rd_data,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] addr,
  output logic              buf_clr,
  output logic              buf_we,
  output logic [7:0]        buf_din,
  output logic              wr_go,
  output logic              allow_q,
  output tw_state_e         st
);

  tw_state_e         st_q, st_d;
  logic [3:0]        bcnt_q, bcnt_d;
  logic [7:0]        rsh_q, rsh_d;
  logic [7:0]        tsh_q, tsh_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              oe_q, oe_d;
  logic              rdm_q, rdm_d;
  logic              mack_q, mack_d;
  logic              pend_q, pend_d;
  logic              allow_d;
  logic              dev_hit;

  assign dev_hit = (rsh_q[7:4] == DEV_PREFIX) && (rsh_q[3:1] == strap);

  always_comb begin
    st_d    = st_q;
    bcnt_d  = bcnt_q;
    rsh_d   = rsh_q;
    tsh_d   = tsh_q;
    addr_d  = addr_q;
    oe_d    = oe_q;
    rdm_d   = rdm_q;
    mack_d  = mack_q;
    pend_d  = pend_q;
    allow_d = allow_q;
    buf_clr = 1'b0;
    buf_we  = 1'b0;
    wr_go   = 1'b0;

    if (busy) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (start_ev) begin
      st_d   = ST_DEV;
      bcnt_d = '0;
      oe_d   = 1'b0;
      pend_d = 1'b0;
    end else if (stop_ev) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
      if (pend_q) begin
        wr_go   = 1'b1;
        pend_d  = 1'b0;
        allow_d = wr_allow;
      end
    end else begin
      unique case (st_q)
        ST_DEV, ST_ADR, ST_WR: begin
          if (scl_rise && (bcnt_q < 4'd8)) begin
            rsh_d  = {rsh_q[6:0], sda_lvl};
            bcnt_d = bcnt_q + 4'd1;
          end else if (scl_fall && (bcnt_q == 4'd8)) begin
            bcnt_d = '0;
            if (st_q == ST_DEV) begin
              if (dev_hit) begin
                oe_d  = 1'b1;
                rdm_d = rsh_q[0];
                st_d  = ST_DEV_ACK;
              end else begin
                st_d = ST_IDLE;
              end
            end else if (st_q == ST_ADR) begin
              oe_d    = 1'b1;
              addr_d  = rsh_q[ADDR_W-1:0];
              buf_clr = 1'b1;
              st_d    = ST_ADR_ACK;
            end else begin
              oe_d   = 1'b1;
              buf_we = 1'b1;
              pend_d = 1'b1;
              addr_d[PAGE_W-1:0] = addr_q[PAGE_W-1:0] + PAGE_W'(1);
              st_d   = ST_WR_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            if (rdm_q) begin
              tsh_d  = rd_data;
              oe_d   = ~rd_data[7];
              bcnt_d = '0;
              st_d   = ST_RD;
            end else begin
              oe_d = 1'b0;
              st_d = ST_ADR;
            end
          end
        end
        ST_ADR_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            oe_d = 1'b0;
            st_d = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bcnt_q == 4'd7) begin
              oe_d   = 1'b0;
              bcnt_d = '0;
              addr_d = addr_q + ADDR_W'(1);
              st_d   = ST_RD_ACK;
            end else begin
              tsh_d  = {tsh_q[6:0], 1'b0};
              oe_d   = ~tsh_q[6];
              bcnt_d = bcnt_q + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              tsh_d = rd_data;
              oe_d  = ~rd_data[7];
              st_d  = ST_RD;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: begin
          st_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      bcnt_q  <= '0;
      rsh_q   <= '0;
      tsh_q   <= '0;
      addr_q  <= '0;
      oe_q    <= 1'b0;
      rdm_q   <= 1'b0;
      mack_q  <= 1'b0;
      pend_q  <= 1'b0;
      allow_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      bcnt_q  <= bcnt_d;
      rsh_q   <= rsh_d;
      tsh_q   <= tsh_d;
      addr_q  <= addr_d;
      oe_q    <= oe_d;
      rdm_q   <= rdm_d;
      mack_q  <= mack_d;
      pend_q  <= pend_d;
      allow_q <= allow_d;
    end
  end

  assign sda_oe  = oe_q;
  assign addr    = addr_q;
  assign buf_din = rsh_q;
  assign st      = st_q;

endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import tw_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned PAGE_W      = 4,
  parameter int unsigned WR_CYCLES   = 625000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_PREFIX  = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wr_allow_i,
  output logic       sda_oe_o
);

  localparam int unsigned PG_W = ADDR_W - PAGE_W;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, done, wr_go, allow_q, commit;
  logic buf_clr, buf_we;
  logic [7:0] buf_din, rd_data;
  logic [ADDR_W-1:0] addr;
  tw_state_e st;

  tw_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  tw_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEV_PREFIX(DEV_PREFIX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .start_ev(start_ev), .stop_ev(stop_ev), .busy(busy),
    .strap(strap_i), .wr_allow(wr_allow_i), .rd_data(rd_data),
    .sda_oe(sda_oe_o), .addr(addr), .buf_clr(buf_clr), .buf_we(buf_we),
    .buf_din(buf_din), .wr_go(wr_go), .allow_q(allow_q), .st(st)
  );

  tw_write_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(wr_go), .busy(busy), .done(done)
  );

  assign commit = done & allow_q;

  tw_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_we(buf_we),
    .buf_idx(addr[PAGE_W-1:0]), .buf_din(buf_din), .commit(commit),
    .page(addr[ADDR_W-1:PAGE_W]), .rd_addr(addr), .rd_data(rd_data)
  );

  logic [PG_W-1:0] unused_pg;
  assign unused_pg = '0;

endmodule

// File: rtl/tw_eeprom_slave_chk.sv
module tw_eeprom_slave_chk
  import tw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PAGE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_lvl,
  input logic              busy,
  input logic              buf_we,
  input logic [ADDR_W-1:0] addr,
  input tw_state_e         st
);

  assert_oe_moves_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_lvl));

  assert_silent_in_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  assert_no_fill_in_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !buf_we);

  assert_page_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])) &&
               (addr[PAGE_W-1:0] == $past(addr[PAGE_W-1:0]) + PAGE_W'(1)));

  assert_read_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD_ACK && $past(st) == ST_RD) |-> (addr == $past(addr) + ADDR_W'(1)));

  assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

endmodule

bind tw_eeprom_slave tw_eeprom_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_lvl(scl_lvl),
  .busy(busy), .buf_we(buf_we), .addr(addr), .st(st)
);

// File: tb/tw_eeprom_slave_bench.sv
module tw_eeprom_slave_bench;

  localparam int WRC = 400;
  localparam int LO  = 12;
  localparam int HI  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wr_allow = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  logic sda_line;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  tw_eeprom_slave #(.WR_CYCLES(WRC)) u_tw_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .wr_allow_i(wr_allow), .sda_oe_o(sda_oe)
  );

  int errs = 0;
  int checks = 0;
  logic [7:0] mdl [256];
  logic [7:0] amdl;
  logic [7:0] wdat [32];

  function automatic logic [7:0] devb(input logic rw);
    return {4'b1010, strap, rw};
  endfunction

  function automatic logic [7:0] in_page(input logic [7:0] a, input int k);
    return {a[7:4], a[3:0] + 4'(k)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitclk(input logic v, output logic s);
    repeat (LO/2) @(negedge clk);
    sda_m = v;
    repeat (LO/2) @(negedge clk);
    scl = 1'b1;
    repeat (HI/2) @(negedge clk);
    s = sda_line;
    repeat (HI/2) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic bstart();
    repeat (LO/2) @(negedge clk);
    sda_m = 1'b1;
    repeat (LO/2) @(negedge clk);
    scl = 1'b1;
    repeat (HI/2) @(negedge clk);
    sda_m = 1'b0;
    repeat (HI/2) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic bstop();
    repeat (LO/2) @(negedge clk);
    sda_m = 1'b0;
    repeat (LO/2) @(negedge clk);
    scl = 1'b1;
    repeat (HI/2) @(negedge clk);
    sda_m = 1'b1;
    repeat (HI/2) @(negedge clk);
  endtask

  task automatic tx(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bitclk(b[i], s);
    bitclk(1'b1, s);
    ack = ~s;
  endtask

  task automatic rx(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bitclk(1'b1, s);
      b[i] = s;
    end
    bitclk(~mack, s);
  endtask

  // write of n bytes from wdat, then busy poll and ready check
  task automatic do_write(input logic [7:0] a, input int n, input logic allow);
    logic ack;
    wr_allow = allow;
    bstart();
    tx(devb(1'b0), ack); chk(ack, "R2 device ack", ack, 1);
    tx(a, ack);          chk(ack, "R2 address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      tx(wdat[i], ack);
      chk(ack, allow ? "R2 data ack" : "R9 data ack while blocked", ack, 1);
    end
    bstop();
    for (int i = 0; i < n; i++) if (allow) mdl[in_page(a, i)] = wdat[i];
    amdl = in_page(a, n);
    if (n > 0) begin
      bstart();
      tx(devb(1'b0), ack); chk(!ack, "R8 no ack during write cycle", ack, 0);
      bstop();
      repeat (WRC) @(negedge clk);
    end
    wr_allow = 1'b1;
    bstart();
    tx(devb(1'b0), ack); chk(ack, "R8 ack after write cycle", ack, 1);
    bstop();
  endtask

  // reads n bytes; a random read first loads address a with a dummy write
  task automatic do_read(input bit rnd, input logic [7:0] a, input int n, input string req);
    logic ack;
    logic [7:0] b;
    bstart();
    if (rnd) begin
      tx(devb(1'b0), ack); chk(ack, "R6 dummy write device ack", ack, 1);
      tx(a, ack);          chk(ack, "R6 dummy write address ack", ack, 1);
      amdl = a;
      bstart();
    end
    tx(devb(1'b1), ack); chk(ack, "R2 read device ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      rx(i < n - 1, b);
      chk(b == mdl[amdl], req, b, mdl[amdl]);
      amdl = amdl + 8'd1;
    end
    repeat (LO/2) @(negedge clk);
    chk(sda_oe == 1'b0, "R7 release after master nack", sda_oe, 0);
    bstop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic ack;
    logic s;
    void'($urandom(32'd7351));
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    amdl = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state
    chk(sda_oe == 1'b0, "R11 sda released after reset", sda_oe, 0);
    do_read(1'b0, 8'h00, 2, "R11 array zero and counter zero");

    // R3 strap and prefix mismatch, then ignored byte
    bstart();
    tx({4'b1010, 3'b100, 1'b0}, ack); chk(!ack, "R3 strap mismatch no ack", ack, 0);
    tx(devb(1'b0), ack);              chk(!ack, "R3 ignored until start", ack, 0);
    bstop();
    bstart();
    tx({4'b0110, strap, 1'b0}, ack);  chk(!ack, "R3 prefix mismatch no ack", ack, 0);
    bstop();

    // R8 byte write, read back
    wdat[0] = 8'h5C;
    do_write(8'h10, 1, 1'b1);
    do_read(1'b1, 8'h10, 1, "R8 byte written");

    // R4 page wrap with 18 bytes starting at 0x2E
    for (int i = 0; i < 18; i++) wdat[i] = 8'(8'h80 + i * 3);
    do_write(8'h2E, 18, 1'b1);
    do_read(1'b1, 8'h20, 16, "R4 page wrap content");

    // R5 array wrap on read and counter hold
    wdat[0] = 8'hE1; wdat[1] = 8'hE2;
    do_write(8'hFE, 2, 1'b1);
    wdat[0] = 8'h01; wdat[1] = 8'h02; wdat[2] = 8'h03;
    do_write(8'h00, 3, 1'b1);
    do_read(1'b1, 8'hFE, 4, "R5 read wraps FF to 00");
    do_read(1'b0, 8'h00, 1, "R5 counter keeps last plus one");

    // R9 write blocked
    wdat[0] = 8'hAA; wdat[1] = 8'hBB;
    do_write(8'h10, 2, 1'b0);
    do_read(1'b1, 8'h10, 2, "R9 array unchanged when blocked");

    // R6 address-only write then stop: no write cycle
    bstart();
    tx(devb(1'b0), ack); tx(8'h22, ack);
    bstop();
    amdl = 8'h22;
    bstart();
    tx(devb(1'b0), ack); chk(ack, "R6 no write cycle after address-only write", ack, 1);
    bstop();
    do_read(1'b0, 8'h00, 1, "R6 counter loaded by address-only write");

    // R10 repeated start after data discards it
    bstart();
    tx(devb(1'b0), ack); tx(8'h30, ack); tx(8'h77, ack);
    do_read(1'b1, 8'h30, 1, "R10 discarded data not written");
    bstart();
    tx(devb(1'b0), ack); chk(ack, "R10 no write cycle after repeated start", ack, 1);
    bstop();

    // R1 start in mid byte
    bstart();
    tx(devb(1'b0), ack); tx(8'h28, ack);
    for (int i = 0; i < 4; i++) bitclk(1'b0, s);
    do_read(1'b1, 8'h28, 3, "R1 partial byte dropped");

    // random mix
    for (int t = 0; t < 10; t++) begin
      int op;
      int n;
      logic [7:0] a;
      op = int'($urandom % 3);
      a  = 8'($urandom);
      if (op == 0) begin
        n = 1 + int'($urandom % 18);
        for (int i = 0; i < n; i++) wdat[i] = 8'($urandom);
        do_write(a, n, ($urandom % 4) != 0);
      end else if (op == 1) begin
        n = 1 + int'($urandom % 6);
        do_read(1'b1, a, n, "R7 sequential random read");
      end else begin
        n = 1 + int'($urandom % 4);
        do_read(1'b0, a, n, "R5 current address read");
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule